// File: doc/BRIEF.md
# Variable-Length Register-Data Instruction Decoder

This block takes a stream of instruction bytes, one byte per accepted transfer, and assembles one register-data instruction of two to four bytes. It then presents a single decoded record downstream. The first byte's high nibble names the operation. Its low nibble, together with a submode nibble in the second byte for the extended form, fixes both how many bytes follow and how wide the operands are. Register numbers arrive scaled (halved for words, quartered for dwords) and are rebuilt into full indices.

Combinations that the operation does not allow are not discarded. They still swallow their computed length, so that the next instruction starts on the right byte, and they are reported with an illegal flag. While a record waits to be taken, the input side is stalled. A fresh instruction is gathered only after the record has been accepted.

Top module: `vlen_insn_decoder`

## Requirements
- R1: The first byte's high nibble maps to the operation code on `out_op`: 2→ADD(0), 9→SUB(1), B→CMP(2), 4→ORL(3), 5→ANL(4), 6→XRL(5), 7→MOV(6), 8→DIV(7), A→MUL(8). Any other high nibble gives code 15 and the illegal flag.
- R2: First-byte low nibble C, D or F is a two-byte register pair with size byte(0), word(1) or dword(2). The second byte's high nibble is the destination field and its low nibble the source field. Both fields are shifted left by 0, 1 or 2 to form the index; `out_mode` is register(0).
- R3: Low nibble E gives an immediate (mode 1) when the second byte's low nibble is 0000 (byte, 8-bit value in byte 3, zero-extended), 0100 (word), 1000 (dword) or 1100 (dword). The last three take a 16-bit value with the high byte first. `out_ext` is 1 only for 1100 under low nibble E.
- R4: Submodes 0001/0101/1101 give an 8-bit direct address (mode 2; byte/word/dword; 3 bytes). Submodes 0011/0111/1111 give a 16-bit direct address, high byte first (mode 3; 4 bytes). The address appears on `out_imm`, and the destination is the scaled second-byte high nibble.
- R5: Submode 1001 (mode 4) and submode 1011 (mode 5) load a byte register through a pointer. The source is the second-byte high nibble shifted left by 1 (1001) or by 2 (1011), and the destination is the third byte's high nibble. A third byte with bits [1:0] not 00 is illegal.
- R6: First byte 0x7A with submode 1100 is a move of a 16-bit immediate into a dword's high half: op code 9, dword, mode 1, ext 0, 4 bytes. Any other submode after 0x7A is illegal.
- R7: DIV and MUL are legal only with low nibble C or D. Submode 1100 under low nibble E is legal only for MOV and CMP. Submode 1111 is legal only for MOV.
- R8: ORL, ANL and XRL are illegal with low nibble F and with submodes 1000, 1100 and 1101.
- R9: An undefined low nibble (not C, D, E, F, and not the 0x7A byte) is a one-byte illegal instruction. An undefined submode (low two bits 10) is a two-byte illegal instruction. For every illegal record, size, mode, indices, immediate and ext read 0.
- R10: An illegal instruction consumes exactly its computed length, so the next byte is decoded as a new first byte.
- R11: `out_valid` and `in_ready` are never high together. A record holds its value until `out_ready`, and `out_valid` drops in the cycle after it is taken. A record appears in the cycle after its last byte is accepted.
- R12: Reset (asynchronous assert, released over two clock edges) clears any partial instruction, leaves `out_valid` low, and restores `in_ready` once released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| in_valid | input | 1 | Instruction byte offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte taken when high with in_valid |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Downstream takes the record |
| out_op | output | 4 | Operation code |
| out_size | output | 2 | 0 byte, 1 word, 2 dword |
| out_mode | output | 3 | 0 reg, 1 imm, 2 dir8, 3 dir16, 4 ptr-word, 5 ptr-dword |
| out_dst | output | 6 | Destination register index |
| out_src | output | 6 | Source / pointer register index |
| out_imm | output | 16 | Immediate or direct address |
| out_ext | output | 1 | Ones-extension of the 16-bit immediate |
| out_illegal | output | 1 | Illegal combination |

## Verification
The decoder has no free top-level parameters: the byte format fixes the 4-bit fields, the 6-bit rebuilt indices and the 16-bit immediate. The bench therefore builds it with the package constants, which put every length (1 to 4), every submode, the largest index (60) and every legality rule within reach. It runs the same instruction list once at full throughput and once with input gaps and downstream stalls. A reset is applied in the middle of a partially gathered instruction.

// File: rtl/vdec_pkg.sv
package vdec_pkg;

  localparam int BYTE_W    = 8;
  localparam int FIELD_W   = 4;
  localparam int SCALE_MAX = 2;
  localparam int REG_IDX_W = FIELD_W + SCALE_MAX;
  localparam int IMM_W     = 2 * BYTE_W;
  localparam int MAX_LEN   = 4;
  localparam int LEN_W     = $clog2(MAX_LEN + 1);
  localparam int CNT_W     = $clog2(MAX_LEN);
  localparam logic [BYTE_W-1:0] MOVH_BYTE = 8'h7A;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_CMP  = 4'd2,
    OP_ORL  = 4'd3,
    OP_ANL  = 4'd4,
    OP_XRL  = 4'd5,
    OP_MOV  = 4'd6,
    OP_DIV  = 4'd7,
    OP_MUL  = 4'd8,
    OP_MOVH = 4'd9,
    OP_BAD  = 4'd15
  } vop_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2
  } vsize_e;

  typedef enum logic [2:0] {
    AM_REG   = 3'd0,
    AM_IMM   = 3'd1,
    AM_DIR8  = 3'd2,
    AM_DIR16 = 3'd3,
    AM_PTR_W = 3'd4,
    AM_PTR_D = 3'd5
  } vmode_e;

  typedef enum logic {
    ST_GATHER = 1'b0,
    ST_HOLD   = 1'b1
  } vstate_e;

  // Rebuild a full register index from a scaled field.
  function automatic logic [REG_IDX_W-1:0] scale_idx(input logic [FIELD_W-1:0] fld,
                                                     input vsize_e sz);
    logic [REG_IDX_W-1:0] wide;
    wide = {{SCALE_MAX{1'b0}}, fld};
    return wide << sz;
  endfunction

endpackage

// File: rtl/vdec_frame.sv
// Instruction length from the first byte and (when needed) the submode nibble.
module vdec_frame
  import vdec_pkg::*;
(
  input  logic [BYTE_W-1:0]  b0_i,
  input  logic [FIELD_W-1:0] sm_i,
  output logic [LEN_W-1:0]   len_o
);

  logic ext_form;

  assign ext_form = (b0_i[3:0] == 4'hE) || (b0_i == MOVH_BYTE);

  always_comb begin
    len_o = LEN_W'(1);
    if (b0_i[3:0] == 4'hC || b0_i[3:0] == 4'hD || b0_i[3:0] == 4'hF) begin
      len_o = LEN_W'(2);
    end else if (ext_form) begin
      case (sm_i)
        4'b0000, 4'b0001, 4'b0101, 4'b1101,
        4'b1001, 4'b1011:                    len_o = LEN_W'(3);
        4'b0100, 4'b1000, 4'b1100,
        4'b0011, 4'b0111, 4'b1111:           len_o = LEN_W'(4);
        default:                             len_o = LEN_W'(2);
      endcase
    end
  end

endmodule

// File: rtl/vdec_legal.sv
// Operation-dependent legality of a gathered instruction.
module vdec_legal
  import vdec_pkg::*;
(
  input  vop_e               op_i,
  input  logic [FIELD_W-1:0] fmt_i,
  input  logic               movh_i,
  input  logic [FIELD_W-1:0] sm_i,
  input  logic [1:0]         ptr_low_i,
  output logic               illegal_o
);

  logic rr_b, rr_w, rr_d, ext_e, ext_form, sm_known, is_logic, is_ptr;

  assign rr_b     = (fmt_i == 4'hC);
  assign rr_w     = (fmt_i == 4'hD);
  assign rr_d     = (fmt_i == 4'hF);
  assign ext_e    = (fmt_i == 4'hE);
  assign ext_form = ext_e || movh_i;
  assign sm_known = (sm_i[1:0] != 2'b10);
  assign is_logic = (op_i == OP_ORL) || (op_i == OP_ANL) || (op_i == OP_XRL);
  assign is_ptr   = (sm_i == 4'b1001) || (sm_i == 4'b1011);

  always_comb begin
    illegal_o = 1'b0;
    if (op_i == OP_BAD)                                         illegal_o = 1'b1;
    if (!(rr_b || rr_w || rr_d || ext_form))                    illegal_o = 1'b1;
    if (ext_form && !sm_known)                                  illegal_o = 1'b1;
    if (movh_i && sm_i != 4'b1100)                              illegal_o = 1'b1;
    if ((op_i == OP_DIV || op_i == OP_MUL) && !(rr_b || rr_w))  illegal_o = 1'b1;
    if (ext_e && sm_i == 4'b1100 && !(op_i == OP_MOV || op_i == OP_CMP))
                                                                illegal_o = 1'b1;
    if (ext_e && sm_i == 4'b1111 && op_i != OP_MOV)             illegal_o = 1'b1;
    if (is_logic && (rr_d || (ext_e && (sm_i == 4'b1000 || sm_i == 4'b1100 ||
                                        sm_i == 4'b1101))))     illegal_o = 1'b1;
    if (ext_form && is_ptr && ptr_low_i != 2'b00)               illegal_o = 1'b1;
  end

endmodule

// File: rtl/vdec_fields.sv
// Field extraction from the gathered bytes; illegal records read as zero.
module vdec_fields
  import vdec_pkg::*;
(
  input  logic [BYTE_W-1:0]    b0_i,
  input  logic [BYTE_W-1:0]    b1_i,
  input  logic [BYTE_W-1:0]    b2_i,
  input  logic [BYTE_W-1:0]    b3_i,
  output vop_e                 op_o,
  output vsize_e               size_o,
  output vmode_e               mode_o,
  output logic [REG_IDX_W-1:0] dst_o,
  output logic [REG_IDX_W-1:0] src_o,
  output logic [IMM_W-1:0]     imm_o,
  output logic                 ext_o,
  output logic                 illegal_o
);

  logic [FIELD_W-1:0]   fmt, sm, f_hi;
  logic                 is_movh, bad;
  vsize_e               r_size;
  vmode_e               r_mode;
  logic [REG_IDX_W-1:0] r_dst, r_src;
  logic [IMM_W-1:0]     r_imm, imm_wide, imm_narrow;
  logic                 r_ext;

  assign fmt        = b0_i[3:0];
  assign sm         = b1_i[3:0];
  assign f_hi       = b1_i[7:4];
  assign is_movh    = (b0_i == MOVH_BYTE);
  assign imm_wide   = {b2_i, b3_i};
  assign imm_narrow = {{BYTE_W{1'b0}}, b2_i};

  always_comb begin
    if (is_movh) begin
      op_o = OP_MOVH;
    end else begin
      case (b0_i[7:4])
        4'h2:    op_o = OP_ADD;
        4'h9:    op_o = OP_SUB;
        4'hB:    op_o = OP_CMP;
        4'h4:    op_o = OP_ORL;
        4'h5:    op_o = OP_ANL;
        4'h6:    op_o = OP_XRL;
        4'h7:    op_o = OP_MOV;
        4'h8:    op_o = OP_DIV;
        4'hA:    op_o = OP_MUL;
        default: op_o = OP_BAD;
      endcase
    end
  end

  always_comb begin
    r_size = SZ_BYTE;
    r_mode = AM_REG;
    r_dst  = '0;
    r_src  = '0;
    r_imm  = '0;
    r_ext  = 1'b0;
    case (fmt)
      4'hC: begin
        r_dst = scale_idx(f_hi, SZ_BYTE);
        r_src = scale_idx(b1_i[3:0], SZ_BYTE);
      end
      4'hD: begin
        r_size = SZ_WORD;
        r_dst  = scale_idx(f_hi, SZ_WORD);
        r_src  = scale_idx(b1_i[3:0], SZ_WORD);
      end
      4'hF: begin
        r_size = SZ_DWORD;
        r_dst  = scale_idx(f_hi, SZ_DWORD);
        r_src  = scale_idx(b1_i[3:0], SZ_DWORD);
      end
      default: begin
        case (sm)
          4'b0000: begin r_mode = AM_IMM;   r_imm = imm_narrow; end
          4'b0100: begin r_mode = AM_IMM;   r_size = SZ_WORD;  r_imm = imm_wide; end
          4'b1000: begin r_mode = AM_IMM;   r_size = SZ_DWORD; r_imm = imm_wide; end
          4'b1100: begin
            r_mode = AM_IMM;
            r_size = SZ_DWORD;
            r_imm  = imm_wide;
            r_ext  = !is_movh;
          end
          4'b0001: begin r_mode = AM_DIR8;  r_imm = imm_narrow; end
          4'b0101: begin r_mode = AM_DIR8;  r_size = SZ_WORD;  r_imm = imm_narrow; end
          4'b1101: begin r_mode = AM_DIR8;  r_size = SZ_DWORD; r_imm = imm_narrow; end
          4'b0011: begin r_mode = AM_DIR16; r_imm = imm_wide; end
          4'b0111: begin r_mode = AM_DIR16; r_size = SZ_WORD;  r_imm = imm_wide; end
          4'b1111: begin r_mode = AM_DIR16; r_size = SZ_DWORD; r_imm = imm_wide; end
          4'b1001: r_mode = AM_PTR_W;
          4'b1011: r_mode = AM_PTR_D;
          default: r_mode = AM_REG;
        endcase
        if (r_mode == AM_PTR_W) begin
          r_dst = scale_idx(b2_i[7:4], SZ_BYTE);
          r_src = scale_idx(f_hi, SZ_WORD);
        end else if (r_mode == AM_PTR_D) begin
          r_dst = scale_idx(b2_i[7:4], SZ_BYTE);
          r_src = scale_idx(f_hi, SZ_DWORD);
        end else begin
          r_dst = scale_idx(f_hi, r_size);
        end
      end
    endcase
  end

  vdec_legal u_legal (
    .op_i      (op_o),
    .fmt_i     (fmt),
    .movh_i    (is_movh),
    .sm_i      (sm),
    .ptr_low_i (b2_i[1:0]),
    .illegal_o (bad)
  );

  assign illegal_o = bad;
  assign size_o    = bad ? SZ_BYTE : r_size;
  assign mode_o    = bad ? AM_REG  : r_mode;
  assign dst_o     = bad ? '0 : r_dst;
  assign src_o     = bad ? '0 : r_src;
  assign imm_o     = bad ? '0 : r_imm;
  assign ext_o     = bad ? 1'b0 : r_ext;

endmodule

// File: rtl/vlen_insn_decoder.sv
module vlen_insn_decoder
  import vdec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [7:0]           in_byte,
  output logic                 in_ready,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [3:0]           out_op,
  output logic [1:0]           out_size,
  output logic [2:0]           out_mode,
  output logic [5:0]           out_dst,
  output logic [5:0]           out_src,
  output logic [15:0]          out_imm,
  output logic                 out_ext,
  output logic                 out_illegal
);

  localparam int SYNC_DEPTH = 2;

  logic [SYNC_DEPTH-1:0]           rst_pipe_q;
  logic                            run;
  vstate_e                         st_q, st_n;
  logic [CNT_W-1:0]                cnt_q, cnt_n;
  logic [MAX_LEN-1:0][BYTE_W-1:0]  bytes_w;
  logic                            take, give, last;
  logic [BYTE_W-1:0]               cur_b0;
  logic [FIELD_W-1:0]              cur_sm;
  logic [LEN_W-1:0]                len_cur;

  vop_e                 f_op;
  vsize_e               f_size;
  vmode_e               f_mode;
  logic [REG_IDX_W-1:0] f_dst, f_src;
  logic [IMM_W-1:0]     f_imm;
  logic                 f_ext, f_bad;

  // Reset release synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_DEPTH-2:0], 1'b1};
  end
  assign run = rst_pipe_q[SYNC_DEPTH-1];

  assign in_ready  = run && (st_q == ST_GATHER);
  assign out_valid = (st_q == ST_HOLD);
  assign take      = in_valid && in_ready;
  assign give      = out_valid && out_ready;

  // Length view including the byte being offered now
  assign cur_b0 = (cnt_q == CNT_W'(0)) ? in_byte : bytes_w[0];
  assign cur_sm = (cnt_q == CNT_W'(1)) ? in_byte[3:0] : bytes_w[1][3:0];

  vdec_frame u_frame (
    .b0_i  (cur_b0),
    .sm_i  (cur_sm),
    .len_o (len_cur)
  );

  assign last = ({1'b0, cnt_q} + LEN_W'(1)) == len_cur;

  // Next state
  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    case (st_q)
      ST_GATHER: begin
        if (take) begin
          if (last) begin
            st_n  = ST_HOLD;
            cnt_n = '0;
          end else begin
            cnt_n = cnt_q + CNT_W'(1);
          end
        end
      end
      default: begin
        if (give) st_n = ST_GATHER;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_GATHER;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  // Byte slots, written in order
  for (genvar gi = 0; gi < MAX_LEN; gi++) begin : g_slot
    logic [BYTE_W-1:0] slot_q;
    logic              slot_en;
    assign slot_en = take && (cnt_q == CNT_W'(gi));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q <= in_byte;
    end
    assign bytes_w[gi] = slot_q;
  end

  vdec_fields u_fields (
    .b0_i      (bytes_w[0]),
    .b1_i      (bytes_w[1]),
    .b2_i      (bytes_w[2]),
    .b3_i      (bytes_w[3]),
    .op_o      (f_op),
    .size_o    (f_size),
    .mode_o    (f_mode),
    .dst_o     (f_dst),
    .src_o     (f_src),
    .imm_o     (f_imm),
    .ext_o     (f_ext),
    .illegal_o (f_bad)
  );

  assign out_op      = f_op;
  assign out_size    = f_size;
  assign out_mode    = f_mode;
  assign out_dst     = f_dst;
  assign out_src     = f_src;
  assign out_imm     = f_imm;
  assign out_ext     = f_ext;
  assign out_illegal = f_bad;

  // Assertions
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);  // R11

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid &&
      $stable({out_op, out_size, out_mode, out_dst, out_src, out_imm, out_ext, out_illegal})));  // R11

  AST_DROP_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    give |=> !out_valid);  // R11

  AST_LAST_BYTE_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    (take && last) |=> out_valid);  // R10

  AST_EXT_DWORD_IMM: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ext) |-> (out_size == 2'd2 && out_mode == 3'd1 && out_op != 4'd9));  // R3

  AST_ILLEGAL_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_imm == '0 && out_dst == '0 && out_src == '0 && !out_ext));  // R9

  AST_NO_RECORD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!out_valid && !in_ready));  // R12

endmodule

// File: tb/vlen_insn_decoder_test.sv
`timescale 1ns/1ps
module vlen_insn_decoder_test;

  localparam int LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_byte;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready;
  logic [3:0]  out_op;
  logic [1:0]  out_size;
  logic [2:0]  out_mode;
  logic [5:0]  out_dst;
  logic [5:0]  out_src;
  logic [15:0] out_imm;
  logic        out_ext;
  logic        out_illegal;

  always #4 clk = ~clk;

  vlen_insn_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_op(out_op), .out_size(out_size), .out_mode(out_mode),
    .out_dst(out_dst), .out_src(out_src), .out_imm(out_imm),
    .out_ext(out_ext), .out_illegal(out_illegal)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit timeout = 0;
  bit fast = 1;

  logic [7:0] stream[$];
  string      tags[$];
  logic [7:0] cur[$];
  bit         m_hold = 0;
  logic [38:0] m_exp;
  string      m_tag;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int ref_len(input logic [7:0] b0, input logic [7:0] b1);
    int lo = int'(b0[3:0]);
    int sm = int'(b1[3:0]);
    if (lo == 12 || lo == 13 || lo == 15) return 2;
    if (lo == 14 || b0 == 8'h7A) begin
      if (sm % 4 == 2) return 2;
      if (sm == 9 || sm == 11) return 3;
      if (sm % 4 == 0) return (sm == 0) ? 3 : 4;
      if (sm % 4 == 1) return 3;
      return 4;
    end
    return 1;
  endfunction

  function automatic logic [38:0] ref_rec(input logic [7:0] b0, input logic [7:0] b1,
                                          input logic [7:0] b2, input logic [7:0] b3);
    int hi = int'(b0[7:4]);
    int lo = int'(b0[3:0]);
    int sm = int'(b1[3:0]);
    int fh = int'(b1[7:4]);
    int op, size, mode, dst, src, imm, ext;
    bit bad = 0;
    bit movh = (b0 == 8'h7A);
    size = 0; mode = 0; dst = 0; src = 0; imm = 0; ext = 0;
    case (hi)
      2: op = 0;  9: op = 1;  11: op = 2; 4: op = 3; 5: op = 4;
      6: op = 5;  7: op = 6;  8: op = 7;  10: op = 8;
      default: op = 15;
    endcase
    if (movh) op = 9;
    if (op == 15) bad = 1;
    if (lo == 12 || lo == 13 || lo == 15) begin
      size = (lo == 12) ? 0 : (lo == 13) ? 1 : 2;
      dst = fh * (1 << size);
      src = int'(b1[3:0]) * (1 << size);
    end else if (lo == 14 || movh) begin
      if (sm == 9 || sm == 11) begin
        mode = (sm == 9) ? 4 : 5;
        dst = int'(b2[7:4]);
        src = fh * ((sm == 9) ? 2 : 4);
        if (b2[1:0] != 2'b00) bad = 1;
      end else if (sm % 4 == 2) begin
        bad = 1;
      end else begin
        if (sm % 4 == 0) begin
          mode = 1;
          size = (sm == 0) ? 0 : (sm == 4) ? 1 : 2;
          imm = (sm == 0) ? int'(b2) : int'(b2) * 256 + int'(b3);
          ext = (sm == 12 && !movh) ? 1 : 0;
        end else if (sm % 4 == 1) begin
          mode = 2;
          size = (sm == 1) ? 0 : (sm == 5) ? 1 : 2;
          imm = int'(b2);
        end else begin
          mode = 3;
          size = (sm == 3) ? 0 : (sm == 7) ? 1 : 2;
          imm = int'(b2) * 256 + int'(b3);
        end
        dst = fh * (1 << size);
      end
    end else begin
      bad = 1;
    end
    if (movh && sm != 12) bad = 1;
    if ((op == 7 || op == 8) && !(lo == 12 || lo == 13)) bad = 1;
    if (lo == 14 && sm == 12 && !(op == 2 || op == 6)) bad = 1;
    if (lo == 14 && sm == 15 && op != 6) bad = 1;
    if ((op >= 3 && op <= 5) && (lo == 15 || (lo == 14 && (sm == 8 || sm == 12 || sm == 13))))
      bad = 1;
    if (bad) return {4'(op), 34'd0, 1'b1};
    return {4'(op), 2'(size), 3'(mode), 6'(dst), 6'(src), 16'(imm), 1'(ext), 1'b0};
  endfunction

  task automatic add(input string tag, input int n, input logic [7:0] a, input logic [7:0] b,
                     input logic [7:0] c, input logic [7:0] d);
    logic [7:0] v[4];
    v[0] = a; v[1] = b; v[2] = c; v[3] = d;
    for (int i = 0; i < n; i++) begin
      stream.push_back(v[i]);
      tags.push_back(tag);
    end
  endtask

  task automatic step();
    logic [38:0] act;
    bit iv, ordy;
    string t;
    logic [7:0] b1, b2, b3;
    @(negedge clk);
    cyc++;
    act = {out_op, out_size, out_mode, out_dst, out_src, out_imm, out_ext, out_illegal};
    chk(in_ready === !m_hold, "R11 in_ready", 64'(in_ready), 64'(!m_hold));
    chk(out_valid === m_hold, "R11 out_valid", 64'(out_valid), 64'(m_hold));
    if (m_hold) chk(act === m_exp, m_tag, 64'(act), 64'(m_exp));
    if (fast) begin
      iv = 1; ordy = 1;
    end else begin
      iv = (cyc % 7) != 5;
      ordy = (cyc % 5) < 2;
    end
    if (stream.size() == 0) iv = 0;
    in_valid  = iv;
    in_byte   = iv ? stream[0] : 8'h00;
    out_ready = ordy;
    if (m_hold) begin
      if (ordy) m_hold = 0;
    end else if (iv) begin
      cur.push_back(stream.pop_front());
      t = tags.pop_front();
      if (cur.size() == 1) m_tag = t;
      b1 = (cur.size() > 1) ? cur[1] : 8'h00;
      if (cur.size() == ref_len(cur[0], b1)) begin
        b2 = (cur.size() > 2) ? cur[2] : 8'h00;
        b3 = (cur.size() > 3) ? cur[3] : 8'h00;
        m_exp  = ref_rec(cur[0], b1, b2, b3);
        m_hold = 1;
        cur.delete();
      end
    end
  endtask

  task automatic run_all();
    while ((stream.size() > 0 || m_hold) && !timeout) begin
      step();
      if (cyc > LIMIT) timeout = 1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00; out_ready = 1'b0;
    m_hold = 0; cur.delete();
    @(negedge clk);
    @(negedge clk);
    chk(out_valid === 1'b0, "R12 valid in reset", 64'(out_valid), 64'd0);
    chk(in_ready === 1'b0, "R12 ready in reset", 64'(in_ready), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1, "R12 ready after release", 64'(in_ready), 64'd1);
    chk(out_valid === 1'b0, "R12 valid after release", 64'(out_valid), 64'd0);
  endtask

  task automatic load_list();
    // R1 operation nibble
    add("R1 add", 2, 8'h2C, 8'h31, 0, 0);
    add("R1 sub", 2, 8'h9C, 8'h12, 0, 0);
    add("R1 cmp", 2, 8'hBC, 8'hF0, 0, 0);
    add("R1 orl", 2, 8'h4C, 8'h7E, 0, 0);
    add("R1 anl", 2, 8'h5C, 8'h0F, 0, 0);
    add("R1 xrl", 2, 8'h6C, 8'hA5, 0, 0);
    add("R1 mov", 2, 8'h7C, 8'h5A, 0, 0);
    add("R1 div", 2, 8'h8C, 8'h21, 0, 0);
    add("R1 mul", 2, 8'hAC, 8'h43, 0, 0);
    // R2 register pairs
    add("R2 word", 2, 8'h2D, 8'h23, 0, 0);
    add("R2 dword", 2, 8'h2F, 8'h5A, 0, 0);
    add("R2 dword max", 2, 8'h7F, 8'hFF, 0, 0);
    add("R2 div word", 2, 8'h8D, 8'h11, 0, 0);
    // R3 immediates
    add("R3 byte imm", 3, 8'h2E, 8'h30, 8'h7F, 0);
    add("R3 word imm", 4, 8'h9E, 8'h24, 8'h12, 8'h34);
    add("R3 dword imm", 4, 8'h2E, 8'h18, 8'hAB, 8'hCD);
    add("R3 mov ext", 4, 8'h7E, 8'h1C, 8'hFF, 8'h00);
    add("R3 cmp ext", 4, 8'hBE, 8'h2C, 8'h80, 8'h01);
    // R4 direct
    add("R4 dir8 byte", 3, 8'h2E, 8'h51, 8'h40, 0);
    add("R4 dir8 word", 3, 8'h7E, 8'h35, 8'h90, 0);
    add("R4 dir8 dword", 3, 8'h7E, 8'h2D, 8'h22, 0);
    add("R4 dir16 byte", 4, 8'h2E, 8'h13, 8'h12, 8'h34);
    add("R4 dir16 word", 4, 8'h9E, 8'h17, 8'hAA, 8'h55);
    add("R4 dir16 dword", 4, 8'h7E, 8'h3F, 8'h01, 8'h02);
    // R5 pointer modes
    add("R5 ptr word", 3, 8'h2E, 8'h39, 8'h50, 0);
    add("R5 ptr dword", 3, 8'h7E, 8'hFB, 8'hA0, 0);
    add("R5 ptr low bits", 3, 8'h2E, 8'h39, 8'h51, 0);
    add("R10 after ptr", 2, 8'h2C, 8'h12, 0, 0);
    // R6 high-half move
    add("R6 movh", 4, 8'h7A, 8'h1C, 8'hBE, 8'hEF);
    add("R6 movh bad sm", 3, 8'h7A, 8'h10, 8'h55, 0);
    // R7 operation limits
    add("R7 div imm", 3, 8'h8E, 8'h30, 8'h12, 0);
    add("R7 mul dword", 2, 8'hAF, 8'h12, 0, 0);
    add("R7 add ext", 4, 8'h2E, 8'h1C, 8'h00, 8'h01);
    add("R7 cmp dir16 dword", 4, 8'hBE, 8'h1F, 8'h12, 8'h34);
    add("R10 after illegal", 3, 8'h9E, 8'h45, 8'h66, 0);
    // R8 logical dword
    add("R8 orl rr dword", 2, 8'h4F, 8'h12, 0, 0);
    add("R8 anl dword imm", 4, 8'h5E, 8'h18, 8'h12, 8'h34);
    add("R8 xrl dir8 dword", 3, 8'h6E, 8'h1D, 8'h40, 0);
    add("R8 orl word imm", 4, 8'h4E, 8'h14, 8'h12, 8'h34);
    // R9 undefined encodings
    add("R9 bad op", 2, 8'h1C, 8'h12, 0, 0);
    add("R9 bad format", 1, 8'h23, 0, 0, 0);
    add("R9 bad format2", 1, 8'h9A, 0, 0, 0);
    add("R9 bad submode", 2, 8'h2E, 8'h12, 0, 0);
    add("R10 realign", 3, 8'h2E, 8'h30, 8'h7F, 0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00; out_ready = 1'b0;
    do_reset();
    fast = 1;
    load_list();
    run_all();
    fast = 0;
    load_list();
    run_all();
    // R12: reset in the middle of a gathered instruction
    fast = 1;
    add("R12 partial", 2, 8'h9E, 8'h24, 0, 0);
    run_all();
    do_reset();
    add("R12 fresh after reset", 2, 8'h2C, 8'h45, 0, 0);
    add("R12 fresh long", 4, 8'h7E, 8'h08, 8'h0F, 8'hF0);
    run_all();
    repeat (2) step();
    if (timeout) begin
      failures++;
      $display("FAIL R11 watchdog actual=%0d expected<%0d", cyc, LIMIT);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule